// File: doc/BRIEF.md
# Power Mode Sequencer

This block keeps a small system-on-chip in one of five operating modes and drives the controls that each mode needs. In Run, every clock is on and memory refresh runs normally. In Slow, the processor clock is halved. In Idle, the sequencer requests and holds the system bus. Sleep gates the internal clocks behind a memory self-refresh handshake. Deep Sleep also turns off the main oscillator and the PLLs. Software changes the mode by writing a code to a small register port. Four asynchronous wake sources bring the system back from either sleep mode.

The whole sequencer runs on the slow always-on clock, so it keeps working while the main clocks are stopped. The wake inputs pass through two-flop synchronisers before the mode logic sees them. The CPU interrupt, DMA bus request, bus grant and self-refresh acknowledge are taken as synchronous to that clock. When the system leaves Deep Sleep, a programmable settling count runs before the clocks come back. A status port shows the current mode and a sticky record of the wake sources that caused the last exit. Software clears that record by writing ones.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode reads Run (code 0). Clock gates and the oscillator/PLL enable are on. Self-refresh, bus request and half-rate select are off, and the wake record is 0.
- R2: A write with select 0 and mode code Run=0, Slow=1 or Idle=2 takes effect at the next clock edge when the current mode is Run, Slow or Idle. The half-rate select is high only in Slow.
- R3: In Idle the bus request is high. A CPU interrupt or a DMA bus request returns the mode to Run at the next edge.
- R4: A request for Sleep (3) or Deep Sleep (4) is accepted only in Idle while the bus grant is high. From any other mode it is ignored, and codes 5 to 7 are always ignored. The bus request stays high for as long as self-refresh is requested.
- R5: Once Sleep is accepted, self-refresh is requested at once (status reads 3). The clock gates turn off only after the memory acknowledges.
- R6: In Deep Sleep (status 4) the oscillator/PLL enable is low, with self-refresh requested and clocks gated.
- R7: A wake input that goes high changes the mode at the third clock edge after it rises. Wake bits are: key 0, alarm 1, reset request 2, ring indicate 3.
- R8: The synchronised ring-indicate input is passed to the interrupt output only while the mode is Run, Slow or Idle.
- R9: On a wake from Deep Sleep the oscillator/PLL enable comes on at once. The clocks stay gated for N+1 cycles, where N is the settling value written with select 2 (reset value from a parameter).
- R10: On exit, the clocks are ungated and self-refresh drops together. The mode returns to Run and releases the bus once the acknowledge falls.
- R11: A synchronised wake that is still high blocks acceptance of a Sleep or Deep Sleep request.
- R12: On each sleep exit, the wake sources that are high are ORed into the wake record. A write with select 1 clears the bits set in data[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 mode request, 1 wake-record clear, 2 settling count |
| cfg_wdata | input | DATA_W | Write data |
| cpu_irq | input | 1 | CPU interrupt pending |
| dma_req | input | 1 | DMA controller wants the bus |
| bus_grant | input | 1 | Arbiter grants the bus to the sequencer |
| sref_ack | input | 1 | Memory controller is in self-refresh |
| wake_key | input | 1 | User wake key (async) |
| wake_alarm | input | 1 | Timer alarm (async) |
| wake_rstreq | input | 1 | Device reset request (async) |
| ring_ind | input | 1 | Modem ring indicate (async) |
| bus_req | output | 1 | Bus mastership request |
| sref_req | output | 1 | Self-refresh request |
| clk_gate_en | output | 1 | Internal clock gate enable |
| osc_pll_en | output | 1 | Main oscillator and PLL enable |
| cpu_half | output | 1 | Processor half-rate select |
| irq_ring | output | 1 | Ring-indicate interrupt |
| stat_mode | output | 3 | Current mode code |
| stat_wake | output | 4 | Sticky wake-source record |

## Verification
Some rules are checked on every cycle: half rate only in Slow, gated clocks only under self-refresh, the oscillator off only while sleeping, self-refresh only while holding the bus, and ring interrupts only in the awake modes. The assertions also check that self-refresh starts only from Idle with a grant, and that an interrupt or DMA request ends Idle at the next edge. Other behaviours only the directed scenarios can show. These include the exact three-edge wake latency, the N+1 settling window, and requests that are ignored or blocked by a pending wake. They also include the order of the exit handshake and the set and clear behaviour of the wake record.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SLOW     = 3'd1,
    ST_IDLE     = 3'd2,
    ST_SLP_ENT  = 3'd3,
    ST_SLEEP    = 3'd4,
    ST_DEEP     = 3'd5,
    ST_OSC_STAB = 3'd6,
    ST_SLP_EXIT = 3'd7
  } pm_state_e;

  localparam logic [2:0] MODE_RUN   = 3'd0;
  localparam logic [2:0] MODE_SLOW  = 3'd1;
  localparam logic [2:0] MODE_IDLE  = 3'd2;
  localparam logic [2:0] MODE_SLEEP = 3'd3;
  localparam logic [2:0] MODE_DEEP  = 3'd4;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_WCLR = 2'd1;
  localparam logic [1:0] SEL_STAB = 2'd2;

  localparam int WAKE_N = 4;

  function automatic logic [2:0] state_to_mode(pm_state_e s);
    case (s)
      ST_RUN:                             state_to_mode = MODE_RUN;
      ST_SLOW:                            state_to_mode = MODE_SLOW;
      ST_IDLE:                            state_to_mode = MODE_IDLE;
      ST_SLP_ENT, ST_SLEEP, ST_SLP_EXIT:  state_to_mode = MODE_SLEEP;
      default:                            state_to_mode = MODE_DEEP;
    endcase
  endfunction
endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_in[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STAB_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              wake_exit,
  input  logic [WAKE_N-1:0] wake_vec,
  output logic              mode_wr,
  output logic [2:0]        mode_code,
  output logic [DATA_W-1:0] stab_val,
  output logic [WAKE_N-1:0] wake_rec
);
  logic [DATA_W-1:0] stab_q;
  logic [WAKE_N-1:0] rec_q, rec_d;
  logic              stab_en, rec_en, clr_wr;

  assign mode_wr   = cfg_we && (cfg_sel == SEL_MODE);
  assign mode_code = cfg_wdata[2:0];
  assign clr_wr    = cfg_we && (cfg_sel == SEL_WCLR);
  assign stab_en   = cfg_we && (cfg_sel == SEL_STAB);
  assign rec_en    = clr_wr || wake_exit;

  always_comb begin
    rec_d = rec_q;
    if (clr_wr)    rec_d = rec_d & ~cfg_wdata[WAKE_N-1:0];
    if (wake_exit) rec_d = rec_d | wake_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stab_q <= DATA_W'(STAB_RST);
    else if (stab_en) stab_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign stab_val = stab_q;
  assign wake_rec = rec_q;
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_code,
  input  logic             cpu_irq,
  input  logic             dma_req,
  input  logic             bus_grant,
  input  logic             sref_ack,
  input  logic             wake_any,
  input  logic [CNT_W-1:0] stab_val,
  output pm_state_e        state,
  output logic             wake_exit
);
  pm_state_e  state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic       deep_q, deep_d;
  logic       cnt_en, deep_en;
  logic       awake_code;

  assign awake_code = (mode_code == MODE_RUN) || (mode_code == MODE_SLOW) ||
                      (mode_code == MODE_IDLE);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    deep_d    = deep_q;
    wake_exit = 1'b0;
    case (state_q)
      ST_RUN, ST_SLOW: begin
        if (mode_wr && awake_code) state_d = pm_state_e'(mode_code);
      end
      ST_IDLE: begin
        if (cpu_irq || dma_req) begin
          state_d = ST_RUN;
        end else if (mode_wr) begin
          if (awake_code) begin
            state_d = pm_state_e'(mode_code);
          end else if ((mode_code == MODE_SLEEP || mode_code == MODE_DEEP) &&
                       bus_grant && !wake_any) begin
            state_d = ST_SLP_ENT;
            deep_d  = (mode_code == MODE_DEEP);
          end
        end
      end
      ST_SLP_ENT: begin
        if (sref_ack) state_d = deep_q ? ST_DEEP : ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_any) begin
          state_d   = ST_SLP_EXIT;
          wake_exit = 1'b1;
        end
      end
      ST_DEEP: begin
        if (wake_any) begin
          state_d   = ST_OSC_STAB;
          cnt_d     = stab_val;
          wake_exit = 1'b1;
        end
      end
      ST_OSC_STAB: begin
        if (cnt_q == '0) state_d = ST_SLP_EXIT;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_SLP_EXIT: begin
        if (!sref_ack) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  assign cnt_en  = (state_q == ST_DEEP) || (state_q == ST_OSC_STAB);
  assign deep_en = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       deep_q <= 1'b0;
    else if (deep_en) deep_q <= deep_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STAB_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cpu_irq,
  input  logic              dma_req,
  input  logic              bus_grant,
  input  logic              sref_ack,
  input  logic              wake_key,
  input  logic              wake_alarm,
  input  logic              wake_rstreq,
  input  logic              ring_ind,
  output logic              bus_req,
  output logic              sref_req,
  output logic              clk_gate_en,
  output logic              osc_pll_en,
  output logic              cpu_half,
  output logic              irq_ring,
  output logic [2:0]        stat_mode,
  output logic [3:0]        stat_wake
);
  localparam int RING_BIT = WAKE_N - 1;

  logic [WAKE_N-1:0] wake_raw, wake_s;
  logic              mode_wr, wake_exit, wake_any;
  logic [2:0]        mode_code;
  logic [DATA_W-1:0] stab_val;
  pm_state_e         state;

  assign wake_raw = {ring_ind, wake_rstreq, wake_alarm, wake_key};
  assign wake_any = |wake_s;

  pmc_wake_sync #(.N(WAKE_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wake_raw),
    .sync_out (wake_s)
  );

  pmc_regs #(.DATA_W(DATA_W), .STAB_RST(STAB_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .wake_exit (wake_exit),
    .wake_vec  (wake_s),
    .mode_wr   (mode_wr),
    .mode_code (mode_code),
    .stab_val  (stab_val),
    .wake_rec  (stat_wake)
  );

  pmc_fsm #(.CNT_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_code (mode_code),
    .cpu_irq   (cpu_irq),
    .dma_req   (dma_req),
    .bus_grant (bus_grant),
    .sref_ack  (sref_ack),
    .wake_any  (wake_any),
    .stab_val  (stab_val),
    .state     (state),
    .wake_exit (wake_exit)
  );

  always_comb begin
    bus_req     = !(state == ST_RUN || state == ST_SLOW);
    sref_req    = (state == ST_SLP_ENT) || (state == ST_SLEEP) ||
                  (state == ST_DEEP) || (state == ST_OSC_STAB);
    clk_gate_en = !((state == ST_SLEEP) || (state == ST_DEEP) ||
                    (state == ST_OSC_STAB));
    osc_pll_en  = (state != ST_DEEP);
    cpu_half    = (state == ST_SLOW);
    irq_ring    = wake_s[RING_BIT] &&
                  ((state == ST_RUN) || (state == ST_SLOW) || (state == ST_IDLE));
    stat_mode   = state_to_mode(state);
  end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_irq,
  input logic       dma_req,
  input logic       bus_grant,
  input logic       bus_req,
  input logic       sref_req,
  input logic       clk_gate_en,
  input logic       osc_pll_en,
  input logic       cpu_half,
  input logic       irq_ring,
  input logic [2:0] stat_mode
);
  AST_HALF_ONLY_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_half |-> (stat_mode == 3'd1));  // R2

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_mode == 3'd2) && (cpu_irq || dma_req)) |=> (stat_mode == 3'd0));  // R3

  AST_SREF_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sref_req) |-> ($past(stat_mode) == 3'd2 && $past(bus_grant)));  // R4

  AST_SREF_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sref_req |-> bus_req);  // R4

  AST_GATED_UNDER_SREF: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> sref_req);  // R5

  AST_OSC_OFF_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_pll_en |-> (sref_req && !clk_gate_en && stat_mode == 3'd4));  // R6

  AST_RING_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ring |-> (stat_mode <= 3'd2));  // R8
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (.*);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int DW = 8;

  logic          clk, rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [DW-1:0] cfg_wdata;
  logic          cpu_irq, dma_req, bus_grant, sref_ack;
  logic          wake_key, wake_alarm, wake_rstreq, ring_ind;
  logic          bus_req, sref_req, clk_gate_en, osc_pll_en, cpu_half, irq_ring;
  logic [2:0]    stat_mode;
  logic [3:0]    stat_wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pwr_mode_ctrl #(.DATA_W(DW), .STAB_RST(16)) u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // arbiter and memory controller models: one-cycle responders
  always @(posedge clk) begin
    bus_grant <= bus_req;
    sref_ack  <= sref_req;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [DW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_mode(logic [2:0] m);
    for (int i = 0; i < 40 && stat_mode != m; i++) @(negedge clk);
  endtask

  task automatic go_idle_granted();
    wr(2'd0, 8'd2);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", stat_mode, 0);
    chk("R1 gate", clk_gate_en, 1);
    chk("R1 osc", osc_pll_en, 1);
    chk("R1 sref", sref_req, 0);
    chk("R1 busreq", bus_req, 0);
    chk("R1 half", cpu_half, 0);
    chk("R1 wake rec", stat_wake, 0);
  endtask

  task automatic t_modes();
    wr(2'd0, 8'd1);
    chk("R2 slow", stat_mode, 1);
    chk("R2 half in slow", cpu_half, 1);
    wr(2'd0, 8'd2);
    chk("R2 idle", stat_mode, 2);
    chk("R2 half off in idle", cpu_half, 0);
    chk("R3 busreq in idle", bus_req, 1);
    wr(2'd0, 8'd0);
    chk("R2 run", stat_mode, 0);
  endtask

  task automatic t_ignored();
    wr(2'd0, 8'd3);
    chk("R4 sleep from run ignored", stat_mode, 0);
    chk("R4 no sref from run", sref_req, 0);
    wr(2'd0, 8'd7);
    chk("R4 code 7 ignored", stat_mode, 0);
    wr(2'd0, 8'd1);
    wr(2'd0, 8'd4);
    chk("R4 deep from slow ignored", stat_mode, 1);
    go_idle_granted();
    wr(2'd0, 8'd5);
    chk("R4 code 5 ignored in idle", stat_mode, 2);
    wr(2'd0, 8'd0);
  endtask

  task automatic t_idle_exit();
    go_idle_granted();
    cpu_irq = 1'b1;
    @(negedge clk);
    cpu_irq = 1'b0;
    chk("R3 irq ends idle", stat_mode, 0);
    chk("R3 bus released", bus_req, 0);
    go_idle_granted();
    dma_req = 1'b1;
    @(negedge clk);
    dma_req = 1'b0;
    chk("R3 dma ends idle", stat_mode, 0);
  endtask

  task automatic t_sleep_key();
    go_idle_granted();
    wr(2'd0, 8'd3);
    chk("R5 sleep accepted", stat_mode, 3);
    chk("R5 sref asserted", sref_req, 1);
    chk("R5 clocks on before ack", clk_gate_en, 1);
    for (int i = 0; i < 10 && clk_gate_en; i++) @(negedge clk);
    chk("R5 clocks gated after ack", clk_gate_en, 0);
    chk("R5 osc stays on", osc_pll_en, 1);
    wake_key = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 still gated after 2 edges", clk_gate_en, 0);
    @(negedge clk);
    chk("R7 ungated at 3rd edge", clk_gate_en, 1);
    chk("R10 sref dropped with ungate", sref_req, 0);
    chk("R10 bus held during exit", bus_req, 1);
    wait_mode(3'd0);
    chk("R10 back to run", stat_mode, 0);
    chk("R10 bus released", bus_req, 0);
    chk("R12 key recorded", stat_wake, 1);
    wake_key = 1'b0;
    wr(2'd1, 8'h1);
    chk("R12 w1c clears", stat_wake, 0);
  endtask

  task automatic t_deep_alarm();
    int win;
    wr(2'd2, 8'd5);
    go_idle_granted();
    wr(2'd0, 8'd4);
    for (int i = 0; i < 10 && osc_pll_en; i++) @(negedge clk);
    chk("R6 osc off in deep", osc_pll_en, 0);
    chk("R6 deep status", stat_mode, 4);
    chk("R6 sref in deep", sref_req, 1);
    chk("R6 gated in deep", clk_gate_en, 0);
    wake_alarm = 1'b1;
    win = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (osc_pll_en && !clk_gate_en) win++;
    end
    chk("R9 settle window N+1", win, 6);
    chk("R10 run after deep", stat_mode, 0);
    chk("R12 alarm recorded", stat_wake, 2);
    wake_alarm = 1'b0;
    wr(2'd1, 8'hF);
    chk("R12 clear all", stat_wake, 0);
  endtask

  task automatic t_pending();
    wake_rstreq = 1'b1;
    repeat (3) @(negedge clk);
    go_idle_granted();
    wr(2'd0, 8'd3);
    chk("R11 pending wake blocks sleep", stat_mode, 2);
    chk("R11 no sref", sref_req, 0);
    wr(2'd0, 8'd4);
    chk("R11 pending wake blocks deep", osc_pll_en, 1);
    wake_rstreq = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'd0);
    chk("R11 no record without exit", stat_wake, 0);
  endtask

  task automatic t_ring();
    ring_ind = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 ring passes in run", irq_ring, 1);
    ring_ind = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 ring cleared", irq_ring, 0);
    go_idle_granted();
    wr(2'd0, 8'd3);
    for (int i = 0; i < 10 && clk_gate_en; i++) @(negedge clk);
    ring_ind = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 exit reads sleep", stat_mode, 3);
    chk("R8 ring blocked while sleeping", irq_ring, 0);
    wait_mode(3'd0);
    chk("R8 ring passes after wake", irq_ring, 1);
    chk("R12 ring recorded", stat_wake, 8);
    ring_ind = 1'b0;
    wr(2'd1, 8'h8);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    cpu_irq = 1'b0; dma_req = 1'b0;
    wake_key = 1'b0; wake_alarm = 1'b0; wake_rstreq = 1'b0; ring_ind = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_ignored();
    t_idle_exit();
    t_sleep_key();
    t_deep_alarm();
    t_pending();
    t_ring();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule